// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Edge Latches

This block collects twenty-eight interrupt sources and reduces them to a single request for a processor. The request is a three-bit level and a five-bit vector offset naming the source that won. Each source owns a four-bit control field. Its low three bits hold a priority from 0 to 7, and priority 0 turns the source off. Its top bit acts as a write-qualifier. Eight fields share one 32-bit word, so four words hold all the fields. The last word has four slots that are not used.

Six sources come from outside the chip and are edge-triggered. They pass through a two-flop synchronizer and an edge detector into a sticky latch. A per-source polarity bit picks the rising or the falling edge. Software clears the latch by writing the field with its top bit set. The other twenty-two sources are internal level inputs. Each is pending for exactly as long as its input is high.

Arbitration is combinational. The output level is the largest priority among sources that are pending and enabled. A tie goes to the smaller vector offset. When nothing qualifies, the level and the offset are both zero.

Top module: `prio_intc`

## Requirements
- R1: After reset all priorities, edge latches and polarity bits are 0, every control word reads 0 when all inputs are low, and irq_level and irq_vector are both 0.
- R2: The source at vector offset v (1..28) sits in word (v-1)/8 (addresses 0..3), bits [31-4*((v-1)%8) -: 4]. On read, bits 2:0 of the field are the priority and bit 3 is the raw pending state. Unused slots in word 3 read 0.
- R3: A write to a control word changes a field's priority only when that field's bit 3 is 1 in the written data. A field whose bit 3 is 0 keeps its value.
- R4: Writing 1 to bit 3 of an external source's field clears its edge latch and loads the priority bits given in the same write.
- R5: The polarity word is at address 4. Bit 32-v serves external offset v: 1 selects the rising edge and 0 the falling edge. A matching edge on the pin is visible as pending on the third rising clock edge after the pin changes. A non-matching edge sets nothing.
- R6: Internal sources (every offset except 1-4, 26 and 27) are pending exactly while their input is high, and need no acknowledge.
- R7: A source with priority 0 never drives irq_level or irq_vector, but its pending bit still reads back.
- R8: irq_level is the maximum priority among pending sources with nonzero priority. irq_vector is the smallest offset holding that priority, and is 0 when no source qualifies.
- R9: If a matching edge reaches the detector in the same cycle as an acknowledge write, the latch stays set.
- R10: Writing 0x88888888 to all four control words sets every priority to 0, so irq_level and irq_vector both become 0.
- R11: The polarity word reads back only the six external bits (31, 30, 29, 28, 6, 5). All other bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| wr_en | input | 1 | Write strobe for the word selected by addr |
| addr | input | 3 | Word select: 0..3 control words, 4 polarity word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr (combinational) |
| src_in | input | 28 | Source inputs; bit v-1 belongs to vector offset v |
| irq_level | output | 3 | Winning priority level, 0 when idle |
| irq_vector | output | 5 | Winning vector offset, 0 when idle |

## Verification
The embedded checks assume that internal source inputs are synchronous to clk. They also assume an external pin holds its value long enough to be seen through the synchronizer. The bench meets this by driving every input on the falling clock edge. It also holds each external pin for at least three cycles after a change before it writes or toggles again. With that spacing, the latch model in the bench only has to decide whether the new pin level matches the polarity. The one exception is the directed case that places an acknowledge write in the detector's edge cycle on purpose.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int WORD_W          = 32;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
  localparam int PRIO_W          = FIELD_W - 1;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic ack,
  output logic pending
);
  logic s1_q, s2_q, prev_q, lat_q;
  logic s1_d, s2_d, prev_d, lat_d;
  logic edge_hit;

  always_comb begin
    s1_d     = pin;
    s2_d     = s1_q;
    prev_d   = s2_q;
    edge_hit = rise_sel ? (s2_q & ~prev_q) : (~s2_q & prev_q);
    if (edge_hit)      lat_d = 1'b1;
    else if (ack)      lat_d = 1'b0;
    else               lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
      lat_q  <= lat_d;
    end
  end

  assign pending = lat_q;

  AST_EDGE_WINS_OVER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pending); // R9
  AST_ACK_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit) |=> !pending); // R4
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(edge_hit)); // R5
endmodule

// File: rtl/pic_ctrl_regs.sv
module pic_ctrl_regs #(
  parameter int          NUM_SRC  = 28,
  parameter int          ADDR_W   = 3,
  parameter logic [27:0] EXT_MASK = 28'h600000F
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [pic_pkg::WORD_W-1:0]             wdata,
  input  logic [NUM_SRC-1:0]                     pend_i,
  output logic [pic_pkg::WORD_W-1:0]             rdata,
  output logic [NUM_SRC-1:0][pic_pkg::PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]                     pol_o,
  output logic [NUM_SRC-1:0]                     ack_o
);
  localparam int FPW      = pic_pkg::FIELDS_PER_WORD;
  localparam int FW       = pic_pkg::FIELD_W;
  localparam int PW       = pic_pkg::PRIO_W;
  localparam int WW       = pic_pkg::WORD_W;
  localparam int NUM_REGS = (NUM_SRC + FPW - 1) / FPW;
  localparam logic [ADDR_W-1:0] POL_ADDR = ADDR_W'(NUM_REGS);

  logic [NUM_SRC-1:0][PW-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0]         pol_q;
  logic                       pol_wr;

  assign pol_wr = wr_en && (addr == POL_ADDR);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    localparam int K   = s / FPW;
    localparam int MSB = WW - 1 - FW * (s % FPW);
    logic hit;

    assign hit       = wr_en && (addr == ADDR_W'(K)) && wdata[MSB];
    assign prio_d[s] = hit ? wdata[MSB-1 -: PW] : prio_q[s];
    assign ack_o[s]  = EXT_MASK[s] ? hit : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[s] <= '0;
      else        prio_q[s] <= prio_d[s];
    end

    if (EXT_MASK[s]) begin : g_pol
      logic pol_d;
      assign pol_d = pol_wr ? wdata[WW-1-s] : pol_q[s];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q[s] <= 1'b0;
        else        pol_q[s] <= pol_d;
      end
    end else begin : g_nopol
      assign pol_q[s] = 1'b0;
    end

    AST_UNQUALIFIED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(K) && !wdata[MSB]) |=> $stable(prio_q[s])); // R3
  end

  always_comb begin
    rdata = '0;
    if (addr == POL_ADDR) begin
      for (int s = 0; s < NUM_SRC; s++)
        if (EXT_MASK[s]) rdata[WW-1-s] = pol_q[s];
    end else begin
      for (int s = 0; s < NUM_SRC; s++)
        if (addr == ADDR_W'(s / FPW))
          rdata[WW-1-FW*(s%FPW) -: FW] = {pend_i[s], prio_q[s]};
    end
  end

  assign prio_o = prio_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 28,
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_SRC-1:0]                      pend_i,
  input  logic [NUM_SRC-1:0][pic_pkg::PRIO_W-1:0] prio_i,
  output logic [pic_pkg::PRIO_W-1:0]              level_o,
  output logic [VEC_W-1:0]                        vector_o
);
  localparam int PW = pic_pkg::PRIO_W;

  always_comb begin
    level_o  = '0;
    vector_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pend_i[s] && (prio_i[s] > level_o)) begin
        level_o  = prio_i[s];
        vector_o = VEC_W'(s + 1);
      end
    end
  end

  AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> (vector_o == '0)); // R8
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o != '0) |-> (pend_i[vector_o - 1'b1] && prio_i[vector_o - 1'b1] == level_o)); // R7
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vector_o <= VEC_W'(NUM_SRC)); // R8
  AST_LEVEL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o == '0) |-> (level_o == PW'(0))); // R8
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int          NUM_SRC  = 28,
  parameter int          ADDR_W   = 3,
  parameter logic [27:0] EXT_MASK = 28'h600000F,
  parameter int          VEC_W    = $clog2(NUM_SRC + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [pic_pkg::WORD_W-1:0]  wdata,
  output logic [pic_pkg::WORD_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0]          src_in,
  output logic [pic_pkg::PRIO_W-1:0]  irq_level,
  output logic [VEC_W-1:0]            irq_vector
);
  logic [NUM_SRC-1:0][pic_pkg::PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]                      pol;
  logic [NUM_SRC-1:0]                      ack;
  logic [NUM_SRC-1:0]                      pend;

  pic_ctrl_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .EXT_MASK(EXT_MASK)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .pend_i(pend),
    .rdata (rdata),
    .prio_o(prio),
    .pol_o (pol),
    .ack_o (ack)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (EXT_MASK[s]) begin : g_edge
      pic_edge_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (src_in[s]),
        .rise_sel(pol[s]),
        .ack     (ack[s]),
        .pending (pend[s])
      );
    end else begin : g_level
      assign pend[s] = src_in[s];
      AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        pend[s] == src_in[s]); // R6
    end
  end

  pic_arbiter #(
    .NUM_SRC(NUM_SRC),
    .VEC_W  (VEC_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .prio_i  (prio),
    .level_o (irq_level),
    .vector_o(irq_vector)
  );
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N = 28;
  localparam logic [27:0] EXT = 28'h600000F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [N-1:0] src_in;
  logic [2:0]  irq_level;
  logic [4:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int prio_m [N];
  bit lat_m  [N];
  bit pol_m  [N];
  bit in_m   [N];

  always #2.5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  function automatic bit pend_m(int s);
    return EXT[s] ? lat_m[s] : in_m[s];
  endfunction

  function automatic logic [31:0] word_m(int k);
    logic [31:0] w = '0;
    for (int s = 0; s < N; s++)
      if (s / 8 == k) w[31-4*(s%8) -: 4] = {pend_m(s), 3'(prio_m[s])};
    return w;
  endfunction

  function automatic logic [31:0] polword_m();
    logic [31:0] w = '0;
    for (int s = 0; s < N; s++) if (EXT[s]) w[31-s] = pol_m[s];
    return w;
  endfunction

  function automatic int lvl_m();
    int b = 0;
    for (int s = 0; s < N; s++) if (pend_m(s) && prio_m[s] > b) b = prio_m[s];
    return b;
  endfunction

  function automatic int vec_m();
    int b = 0, v = 0;
    for (int s = 0; s < N; s++)
      if (pend_m(s) && prio_m[s] > b) begin b = prio_m[s]; v = s + 1; end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd4) begin
      for (int s = 0; s < N; s++)
        if (s / 8 == a && d[31-4*(s%8)]) begin
          prio_m[s] = int'(d[30-4*(s%8) -: 3]);
          if (EXT[s]) lat_m[s] = 1'b0;
        end
    end else if (a == 3'd4) begin
      for (int s = 0; s < N; s++) if (EXT[s]) pol_m[s] = d[31-s];
    end
  endtask

  task automatic read_chk(string tag, logic [2:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic check_all(string tag);
    @(negedge clk);
    for (int k = 0; k < 4; k++) read_chk({tag, " R2 word"}, 3'(k), word_m(k));
    read_chk({tag, " R11 pol"}, 3'd4, polword_m());
    check({tag, " R8 level"}, 32'(irq_level), 32'(lvl_m()));
    check({tag, " R8 vector"}, 32'(irq_vector), 32'(vec_m()));
  endtask

  task automatic set_int(int s, bit v);
    @(negedge clk);
    src_in[s] = v; in_m[s] = v;
  endtask

  task automatic set_ext(int s, bit v);
    @(negedge clk);
    if (in_m[s] != v && (v == pol_m[s])) lat_m[s] = 1'b1;
    src_in[s] = v; in_m[s] = v;
    repeat (3) @(negedge clk);
  endtask

  int ints[$];
  int exts[$];

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int s = 0; s < N; s++) begin
      prio_m[s] = 0; lat_m[s] = 0; pol_m[s] = 0; in_m[s] = 0;
      if (EXT[s]) exts.push_back(s); else ints.push_back(s);
    end
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check_all("R1 reset");

    // R3: qualified write sets offset 1 to priority 5; unqualified write keeps it
    bus_write(3'd0, 32'hD000_0000);
    check_all("R3 set");
    bus_write(3'd0, 32'h5777_7777);
    check_all("R3 hold");

    // R6: internal offset 5 at priority 3
    bus_write(3'd0, 32'h0000_B000);
    set_int(4, 1'b1);
    check_all("R6 high");
    set_int(4, 1'b0);
    check_all("R6 low");

    // R5: default falling polarity; rising edge sets nothing, falling sets
    set_ext(0, 1'b1);
    check_all("R5 rise ignored");
    set_ext(0, 1'b0);
    check_all("R5 fall latched");

    // R4: acknowledge with same priority
    bus_write(3'd0, 32'hD000_0000);
    check_all("R4 ack");

    // R11: only external polarity bits stick
    bus_write(3'd4, 32'hFFFF_FFFF);
    read_chk("R11 readback", 3'd4, 32'hF000_0060);
    bus_write(3'd4, 32'h8000_0000);

    // R8: tie between offsets 9 and 10 at priority 6
    bus_write(3'd1, 32'hEE00_0000);
    set_int(9, 1'b1);
    set_int(8, 1'b1);
    check_all("R8 tie");
    check("R8 tie winner", 32'(irq_vector), 32'd9);

    // R7: priority 0 source still reads pending but does not win
    bus_write(3'd1, 32'h8800_0000);
    check_all("R7 disabled");
    check("R7 idle vector", 32'(irq_vector), 32'd0);
    set_int(8, 1'b0);
    set_int(9, 1'b0);

    // R9: edge arriving with acknowledge write keeps latch set
    @(negedge clk);
    src_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 32'hD000_0000;
    @(negedge clk);
    wr_en = 1'b0;
    in_m[0] = 1'b1; lat_m[0] = 1'b1; prio_m[0] = 5;
    check_all("R9 ack+edge");
    check("R9 pending vector", 32'(irq_vector), 32'd1);

    // R10: mask all
    set_int(20, 1'b1);
    bus_write(3'd0, 32'h8888_8888);
    bus_write(3'd1, 32'h8888_8888);
    bus_write(3'd2, 32'h8888_8888);
    bus_write(3'd3, 32'h8888_8888);
    for (int s = 0; s < N; s++) lat_m[s] = 1'b0;
    set_ext(25, 1'b1);
    check_all("R10 masked");
    check("R10 level", 32'(irq_level), 32'd0);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      case (op)
        0: bus_write(3'($urandom_range(0, 3)), $urandom());
        1: begin
          int s = ints[$urandom_range(0, ints.size() - 1)];
          set_int(s, ~in_m[s]);
        end
        2: begin
          int s = exts[$urandom_range(0, exts.size() - 1)];
          set_ext(s, ~in_m[s]);
        end
        default: bus_write(3'd4, $urandom());
      endcase
      check_all("rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule